// File: doc/BRIEF.md
# GPIO Pin Event Interrupt Detector

This block turns a bank of asynchronous pin inputs into interrupt requests. Each pin first passes through a two-flop synchronizer. Four events are then derived for every pin: two level conditions (pin reads 0, pin reads 1) and two transitions (falling, rising). The level conditions are reported live and follow the pin. The transitions are caught in a sticky raw status that software acknowledges by writing ones.

Three consumers share that one raw status: two processor cores and a dormant-wake path. Each consumer owns a private enable set of the same shape as the status. It also drives its own registered request line, which is high while any enabled status bit is set. A simple synchronous register port gives access to the status, the acknowledge and the three enable sets.

Top module: `pin_event_irq`

## Requirements
- R1: After reset every register is zero and every output is low. A pin change reaches the status through two synchronizer flops. An enabled level event therefore raises its request output at the third rising clock edge after the pin changes, and not at the second.
- R2: Pin p sits in status word p/8 at bits 4*(p%8) to 4*(p%8)+3, with bit 0 = level low, bit 1 = level high, bit 2 = falling edge and bit 3 = rising edge. The register address is {region[1:0], word[1:0]}, where region 0 is the raw status, region 1 is the core 0 enables, region 2 is the core 1 enables and region 3 is the wake enables. Enable words read back as written.
- R3: The level-low bit is 1 exactly while the synchronized pin is 0, and the level-high bit exactly while it is 1. Neither is latched.
- R4: A falling or rising edge bit, once set, stays set through later pin changes until it is acknowledged.
- R5: Writing 1 to an edge bit in the status region clears it. Writing 0 leaves it unchanged. Writing 1 to a level bit has no effect.
- R6: When an edge is detected in the same cycle as an acknowledge of that same bit, the edge wins and the bit stays set.
- R7: Each request output is a registered OR, over all pins and events, of the status ANDed with that consumer's enable set. It is low when that set is all zero.
- R8: The three enable sets are independent: an event enabled only for one consumer raises only that consumer's output.
- R9: Enable bits beyond the last pin (bits 24 to 31 of word 3 with 30 pins) always read 0 and cannot be set.
- R10: A read request presents its data on rd_data with rd_valid high on the cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address {region, word} |
| wr_data | input | 32 | Write data: enable word, or acknowledge mask in the status region |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read address {region, word} |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | rd_data holds the result of the previous read request |
| irq_core0 | output | 1 | Request line for core 0 |
| irq_core1 | output | 1 | Request line for core 1 |
| wake_req | output | 1 | Dormant-wake request |

## Verification
The bench drives a single pin up and down to show that level bits track the pin while edge bits accumulate. It drives two pins together in one word to show that their nibbles are placed independently. An acknowledge issued in the exact cycle a new edge is latched distinguishes edge-wins priority from clear-wins. A timed pulse on an enabled level event pins the synchronizer depth to the cycle. Separate events enabled in each of the three sets show which output responds, and an all-ones write to the last enable word exposes whether the padding bits can be stored.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;
  localparam int EV_W          = 4;
  localparam int EV_LOW        = 0;
  localparam int EV_HIGH       = 1;
  localparam int EV_FALL       = 2;
  localparam int EV_RISE       = 3;
  localparam int WORD_W        = 32;
  localparam int PINS_PER_WORD = WORD_W / EV_W;
  localparam int NCONS         = 3;
  localparam int CONS_CORE0    = 0;
  localparam int CONS_CORE1    = 1;
  localparam int CONS_WAKE     = 2;
  localparam int RGN_W         = 2;

  typedef enum logic [RGN_W-1:0] {
    RGN_STATUS   = 2'd0,
    RGN_EN_CORE0 = 2'd1,
    RGN_EN_CORE1 = 2'd2,
    RGN_EN_WAKE  = 2'd3
  } region_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 30,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/event_status.sv
module event_status
  import pin_event_pkg::*;
#(
  parameter  int NPINS = 30,
  localparam int SW    = NPINS * EV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] clr_fall_i,
  input  logic [NPINS-1:0] clr_rise_i,
  output logic [SW-1:0]    status_o
);
  logic [NPINS-1:0] prev_q, fall_q, rise_q;
  logic [NPINS-1:0] fall_det, rise_det;

  always_comb begin
    rise_det = lvl_i & ~prev_q;
    fall_det = ~lvl_i & prev_q;
  end

  // a fresh edge is ORed in after the clear, so it survives a same-cycle ack
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      fall_q <= '0;
      rise_q <= '0;
    end else begin
      prev_q <= lvl_i;
      fall_q <= (fall_q & ~clr_fall_i) | fall_det;
      rise_q <= (rise_q & ~clr_rise_i) | rise_det;
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign status_o[p*EV_W+EV_LOW]  = ~lvl_i[p];
    assign status_o[p*EV_W+EV_HIGH] = lvl_i[p];
    assign status_o[p*EV_W+EV_FALL] = fall_q[p];
    assign status_o[p*EV_W+EV_RISE] = rise_q[p];
  end

  assert_edge_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (({fall_q, rise_q} & ~{clr_fall_i, clr_rise_i}) != '0) |=>
      (({fall_q, rise_q} & $past({fall_q, rise_q} & ~{clr_fall_i, clr_rise_i}))
        == $past({fall_q, rise_q} & ~{clr_fall_i, clr_rise_i})));

  assert_edge_wins_R6: assert property (@(posedge clk) disable iff (rst)
    ({fall_det, rise_det} != '0) |=>
      (({fall_q, rise_q} & $past({fall_det, rise_det})) == $past({fall_det, rise_det})));

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (({clr_fall_i, clr_rise_i} & ~{fall_det, rise_det}) != '0) |=>
      (({fall_q, rise_q} & $past({clr_fall_i, clr_rise_i} & ~{fall_det, rise_det})) == '0));

  assert_no_phantom_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (({fall_q, rise_q} & ~$past({fall_q, rise_q}) & ~$past({fall_det, rise_det})) == '0));
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import pin_event_pkg::*;
#(
  parameter  int NPINS  = 30,
  parameter  int NSLOTS = 4,
  parameter  int SLOT_W = 2,
  localparam int SW     = NPINS * EV_W,
  localparam int EW     = NSLOTS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SW-1:0]     status_i,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [EW-1:0]     en_o,
  output logic              irq_o
);
  function automatic logic [EW-1:0] valid_bits();
    logic [EW-1:0] m;
    for (int b = 0; b < EW; b++) m[b] = (b < SW);
    return m;
  endfunction

  localparam logic [EW-1:0] VALID = valid_bits();

  logic [EW-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      irq_o <= 1'b0;
    end else begin
      if (wr_en_i) begin
        for (int s = 0; s < NSLOTS; s++) begin
          if (wr_slot_i == SLOT_W'(s))
            en_q[s*WORD_W +: WORD_W] <= wr_data_i & VALID[s*WORD_W +: WORD_W];
        end
      end
      irq_o <= |(en_q[SW-1:0] & status_i);
    end
  end

  assign en_o = en_q;

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq_o);

  assert_pad_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (en_q & ~VALID) == '0);
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
  import pin_event_pkg::*;
#(
  parameter  int NPINS       = 30,
  parameter  int SYNC_STAGES = 2,
  localparam int NWORDS      = (NPINS * EV_W + WORD_W - 1) / WORD_W,
  localparam int SLOT_W      = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int ADDR_W      = RGN_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              irq_core0,
  output logic              irq_core1,
  output logic              wake_req
);
  localparam int NSLOTS = 1 << SLOT_W;
  localparam int SW     = NPINS * EV_W;
  localparam int PW     = NSLOTS * WORD_W;

  logic [NPINS-1:0]  lvl;
  logic [SW-1:0]     status;
  logic [PW-1:0]     stat_pad;
  logic [NPINS-1:0]  clr_fall, clr_rise;
  logic [NCONS-1:0]  irq_vec;
  logic [PW-1:0]     en_flat [NCONS];
  logic [RGN_W-1:0]  wr_rgn, rd_rgn;
  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic              ack_wr;
  logic [WORD_W-1:0] rd_word;

  pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(pin_i), .sync_o(lvl)
  );

  assign wr_rgn  = wr_addr[ADDR_W-1 -: RGN_W];
  assign wr_slot = wr_addr[SLOT_W-1:0];
  assign rd_rgn  = rd_addr[ADDR_W-1 -: RGN_W];
  assign rd_slot = rd_addr[SLOT_W-1:0];
  assign ack_wr  = wr_en && (region_e'(wr_rgn) == RGN_STATUS);

  // acknowledge decode: only edge positions of the addressed word are honoured
  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      clr_fall[p] = ack_wr && (wr_slot == SLOT_W'(p / PINS_PER_WORD)) &&
                    wr_data[(p % PINS_PER_WORD) * EV_W + EV_FALL];
      clr_rise[p] = ack_wr && (wr_slot == SLOT_W'(p / PINS_PER_WORD)) &&
                    wr_data[(p % PINS_PER_WORD) * EV_W + EV_RISE];
    end
  end

  event_status #(.NPINS(NPINS)) u_status (
    .clk(clk), .rst(rst), .lvl_i(lvl),
    .clr_fall_i(clr_fall), .clr_rise_i(clr_rise), .status_o(status)
  );

  for (genvar c = 0; c < NCONS; c++) begin : g_cons
    irq_combiner #(.NPINS(NPINS), .NSLOTS(NSLOTS), .SLOT_W(SLOT_W)) u_comb (
      .clk(clk), .rst(rst), .status_i(status),
      .wr_en_i(wr_en && (wr_rgn == RGN_W'(c + 1))),
      .wr_slot_i(wr_slot), .wr_data_i(wr_data),
      .en_o(en_flat[c]), .irq_o(irq_vec[c])
    );
  end

  assign stat_pad = PW'(status);

  always_comb begin
    rd_word = '0;
    if (region_e'(rd_rgn) == RGN_STATUS) begin
      rd_word = stat_pad[rd_slot*WORD_W +: WORD_W];
    end else begin
      for (int c = 0; c < NCONS; c++) begin
        if (rd_rgn == RGN_W'(c + 1)) rd_word = en_flat[c][rd_slot*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_word;
    end
  end

  assign irq_core0 = irq_vec[CONS_CORE0];
  assign irq_core1 = irq_vec[CONS_CORE1];
  assign wake_req  = irq_vec[CONS_WAKE];

  assert_rd_valid_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_rd_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

// File: tb/pin_event_irq_bench.sv
`timescale 1ns/1ps
module pin_event_irq_bench;
  localparam int NPINS = 30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NPINS-1:0] pin_i = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid, irq_core0, irq_core1, wake_req;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] exp_v;
  string       tag_v;

  always #5 clk = ~clk;

  pin_event_irq u_pin_event_irq (
    .clk(clk), .rst(rst), .pin_i(pin_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .irq_core0(irq_core0), .irq_core1(irq_core1), .wake_req(wake_req)
  );

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic write_reg(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // driver: issue a read and push its expected value to the scoreboard
  task automatic read_exp(logic [3:0] a, logic [31:0] e, string tag);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic set_pin(int idx, logic v);
    @(negedge clk); pin_i[idx] = v;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: compare every returned read against the scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected rd_valid got %h expected none", rd_data);
      end else begin
        exp_v = exp_q.pop_front();
        tag_v = tag_q.pop_front();
        if (rd_data !== exp_v) begin
          errors++;
          $display("FAIL %s rd_data got %h expected %h", tag_v, rd_data, exp_v);
        end
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL R10 watchdog got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state and R2 layout: all pins low show level-low only
    check_bit("R1 irq_core0 after reset", irq_core0, 1'b0);
    check_bit("R1 irq_core1 after reset", irq_core1, 1'b0);
    check_bit("R1 wake_req after reset", wake_req, 1'b0);
    check_bit("R1 rd_valid after reset", rd_valid, 1'b0);
    read_exp(4'h0, 32'h11111111, "R1 status word0 at reset");
    read_exp(4'h3, 32'h00111111, "R2 status word3 at reset");
    read_exp(4'h4, 32'h00000000, "R1 core0 enable word0 at reset");

    // R3 level tracks, R4 edge sticks
    set_pin(5, 1'b1); settle();
    read_exp(4'h0, 32'h11A11111, "R3 pin5 high level plus rise");
    set_pin(5, 1'b0); settle();
    read_exp(4'h0, 32'h11D11111, "R4 pin5 low keeps rise adds fall");

    // R5 acknowledge: rise plus level-low bit written, level unaffected
    write_reg(4'h0, 32'h00900000);
    read_exp(4'h0, 32'h11511111, "R5 rise cleared level kept");
    write_reg(4'h0, 32'h00000000);
    read_exp(4'h0, 32'h11511111, "R5 zero write no change");
    write_reg(4'h0, 32'h00400000);
    read_exp(4'h0, 32'h11111111, "R5 fall cleared");

    // R6 acknowledge lands in the cycle the rise is latched
    set_pin(9, 1'b1);
    @(negedge clk);
    write_reg(4'h1, 32'h00000080);
    read_exp(4'h1, 32'h111111A1, "R6 edge wins over same-cycle ack");
    write_reg(4'h1, 32'h00000080);
    read_exp(4'h1, 32'h11111121, "R5 later ack clears rise");
    set_pin(9, 1'b0); settle();
    read_exp(4'h1, 32'h11111151, "R4 pin9 fall latched");
    write_reg(4'h1, 32'h00000040);
    read_exp(4'h1, 32'h11111111, "R5 pin9 fall cleared");

    // R1 latency and R7 level enable on core 0
    write_reg(4'h4, 32'h00000002);
    settle();
    check_bit("R7 core0 idle with pin0 low", irq_core0, 1'b0);
    set_pin(0, 1'b1);
    @(negedge clk);
    @(negedge clk);
    check_bit("R1 core0 not yet at second edge", irq_core0, 1'b0);
    @(negedge clk);
    check_bit("R1 core0 raised at third edge", irq_core0, 1'b1);
    check_bit("R8 core1 unaffected by core0 enable", irq_core1, 1'b0);
    check_bit("R8 wake unaffected by core0 enable", wake_req, 1'b0);
    set_pin(0, 1'b0); settle();
    check_bit("R3 core0 drops with level", irq_core0, 1'b0);
    write_reg(4'h4, 32'h00000000);
    write_reg(4'h0, 32'h0000000C);
    read_exp(4'h0, 32'h11111111, "R5 pin0 edges cleared");

    // R4 and R8: core 1 on rise of pin 29
    write_reg(4'hB, 32'h00800000);
    set_pin(29, 1'b1); settle();
    set_pin(29, 1'b0); settle();
    check_bit("R4 core1 held by sticky rise", irq_core1, 1'b1);
    check_bit("R8 core0 quiet for core1 event", irq_core0, 1'b0);
    check_bit("R8 wake quiet for core1 event", wake_req, 1'b0);
    read_exp(4'h3, 32'h00D11111, "R2 pin29 nibble in word3");
    write_reg(4'h3, 32'h00800000); settle();
    check_bit("R7 core1 drops after ack", irq_core1, 1'b0);
    read_exp(4'h3, 32'h00511111, "R5 pin29 rise cleared");
    write_reg(4'h3, 32'h00400000);
    write_reg(4'hB, 32'h00000000);

    // R8 wake set on fall of pin 12
    write_reg(4'hD, 32'h00040000);
    read_exp(4'hD, 32'h00040000, "R2 wake enable readback");
    set_pin(12, 1'b1); settle();
    check_bit("R7 wake idle on rise only", wake_req, 1'b0);
    set_pin(12, 1'b0); settle();
    check_bit("R8 wake on pin12 fall", wake_req, 1'b1);
    check_bit("R8 core0 quiet for wake event", irq_core0, 1'b0);
    check_bit("R8 core1 quiet for wake event", irq_core1, 1'b0);
    write_reg(4'h1, 32'h000C0000); settle();
    check_bit("R7 wake drops after ack", wake_req, 1'b0);
    write_reg(4'hD, 32'h00000000);

    // R9 padding bits of the last word
    write_reg(4'hB, 32'hFFFFFFFF);
    read_exp(4'hB, 32'h00FFFFFF, "R9 padding enable bits read zero");
    settle();
    check_bit("R7 core1 on level-low enables", irq_core1, 1'b1);
    read_exp(4'h7, 32'h00000000, "R8 core0 word3 untouched");
    write_reg(4'hB, 32'h00000000); settle();
    check_bit("R7 core1 off when disabled", irq_core1, 1'b0);

    // R2 enable words store independently
    write_reg(4'h5, 32'h12345678);
    read_exp(4'h5, 32'h12345678, "R2 core0 word1 readback");
    read_exp(4'h9, 32'h00000000, "R8 core1 word1 untouched");
    read_exp(4'hD, 32'h00000000, "R8 wake word1 untouched");
    write_reg(4'h5, 32'h00000000);

    // R3 two pins in one word together
    @(negedge clk); pin_i[16] = 1'b1; pin_i[17] = 1'b1;
    settle();
    read_exp(4'h2, 32'h111111AA, "R3 pins16 17 high together");
    @(negedge clk); pin_i[16] = 1'b0; pin_i[17] = 1'b0;
    settle();
    read_exp(4'h2, 32'h111111DD, "R4 pins16 17 both edges kept");
    write_reg(4'h2, 32'h000000CC);
    read_exp(4'h2, 32'h11111111, "R5 pins16 17 cleared");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 reads outstanding got %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule